// File: doc/BRIEF.md
# NOR Flash Command and Status Controller

This block models the command side of a byte-wide, single-supply NOR flash whose address space spans 262,144 bytes split into equal sectors. A host drives an asynchronous-style bus (active-low chip enable, write enable and output enable) that the block samples on its own clock. Multi-cycle unlock sequences written to the command decoder start an embedded program or an embedded sector erase. These run against an internal byte array. The durations of the program and erase phases come from cycle-count parameters, not from cell physics.

While an operation runs, a read returns a status byte instead of array data. Bit 7 carries the complement of the final value expected in bit 7, and bit 6 flips after every completed read. The host polls until two consecutive reads agree. An erase first drives every byte of the selected sectors to 00, then waits out the erase timer, then sets them to FF. The erase can be suspended so that other sectors can be read or programmed, and then resumed. Protected sectors, a low-supply inhibit and an active-low reset complete the control set.

Each sector is held as a reduced window of `WIN_BYTES` locations. The top address bits select the sector and the low address bits select a window byte. The bits in between alias.

Top module: `nor_flash_ctl`

## Requirements
- R1: The array index is {addr[17:16], addr[3:0]} with the default parameters, so addresses that differ only in bits 15..4 reach the same byte. Every byte reads FF before its first program. With ceN and oeN both low and no operation running, dataOut shows the indexed byte in the same cycle.
- R2: A write cycle ends at the first clock edge at which ceN or weN is high after both were low. The data/address pairs are decoded in this order. Program is AA@555, 55@2AA, A0, then the target address and data. Erase is AA@555, 55@2AA, 80, AA@555, 55@2AA, then 30 at a sector address. Unlock addresses compare addr[10:0] only. Any other write at any step, F0 included, returns the block to read mode.
- R3: While an operation runs, a read returns a status byte. Bit 7 is the inverse of bit 7 of the programmed data, or 0 during an erase. Bit 6 inverts at the end of each read cycle. Bits 5..0 are 0.
- R4: A program ANDs the data into the target byte (bits only go 1 to 0) after PROG_CYCLES clock cycles. Writes issued while it runs are ignored.
- R5: Each further 30 written within SEL_WINDOW cycles of the previous one adds its sector to the erase. Any other write in that window cancels the erase. The erase writes 00 to every byte of the selected sectors, waits ERASE_CYCLES, then writes FF to them. Other sectors keep their data.
- R6: A sector whose protMask bit is 1 ignores both program and erase. A program to it returns to read mode at once, and an erase that selects only protected sectors never starts running.
- R7: B0 written during the preprogram, timer or erase phase suspends the erase. While suspended, every read returns array data. A program to a sector outside the erase completes normally, and a program into an erasing sector is ignored. A later 30 resumes the erase from the point where it stopped.
- R8: rstN low aborts any operation and returns the block to read mode without changing the array.
- R9: Write cycles that end while lowVcc is 1 are ignored.
- R10: dataOe is 1 only while ceN and oeN are both low. Otherwise dataOut is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low hardware reset, aborts operations |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or status byte |
| dataOe | output | 1 | High when dataOut is driven |
| lowVcc | input | 1 | Low-supply detect, blocks writes |
| protMask | input | SECTOR_CNT | One protect bit per sector |

## Verification
Read data and status are combinational from the sampled bus, so the bench samples 1 ns after it drives ceN and oeN low on a falling edge. A command takes effect at the rising edge that follows the release of the write strobe. Every bus task therefore returns on a falling edge, and the next action waits one more falling edge. The status toggle moves at the edge after a read ends, so back-to-back reads are separated by a full cycle. Operation completion is never counted in cycles. The bench polls until two reads agree, and only the suspend test relies on a cycle count: 80 cycles after the last 30 lands the erase inside its timer phase.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic tgtLatch;   // copy last write address/data into program target
    logic progWr;     // AND target data into target byte
    logic preWr;      // write 00 at scan index
    logic ersWr;      // write FF at scan index
    logic busy;       // embedded operation running, reads return status
    logic ersMode;    // running operation is an erase
  } nfcStrb_t;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PWAIT, S_PRUN,
    S_EUNL3, S_EUNL4, S_EUNL5, S_ESEL,
    S_EPRE, S_ETIME, S_EERS, S_SUSP
  } nfcState_t;

endpackage

// File: rtl/nfc_datapath.sv
module nfc_datapath
  import nfc_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SECTOR_CNT = 4,
  parameter int WIN_BYTES  = 16,
  localparam int SEC_W = $clog2(SECTOR_CNT),
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int IDX_W = SEC_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  nfcStrb_t          strb,
  input  logic [IDX_W-1:0]  scanIdx,
  output logic              wrEnd,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam int MEM_N = SECTOR_CNT * WIN_BYTES;

  logic       wrNow, wrPrev, rdNow, rdPrev, togBit;
  logic [7:0] tgtData;
  logic [7:0] mem [MEM_N];
  logic [IDX_W-1:0] tgtIdx, rdIdx;
  logic [7:0] statusByte;

  assign wrNow = !ceN && !weN;
  assign rdNow = !ceN && !oeN;
  assign wrEnd = wrPrev && !wrNow;

  // bus capture, program target and status toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      rdPrev  <= 1'b0;
      togBit  <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      tgtAddr <= '0;
      tgtData <= '0;
    end else begin
      wrPrev <= wrNow;
      rdPrev <= rdNow;
      if (wrNow) begin
        wrAddr <= addr;
        wrData <= dataIn;
      end
      if (strb.tgtLatch) begin
        tgtAddr <= wrAddr;
        tgtData <= wrData;
      end
      if (rdPrev && !rdNow && strb.busy) togBit <= !togBit;
    end
  end

  assign tgtIdx = {tgtAddr[ADDR_W-1 -: SEC_W], tgtAddr[OFF_W-1:0]};
  assign rdIdx  = {addr[ADDR_W-1 -: SEC_W], addr[OFF_W-1:0]};

  // array starts fully erased
  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (strb.progWr) mem[tgtIdx] <= mem[tgtIdx] & tgtData;
    if (strb.preWr)  mem[scanIdx] <= 8'h00;
    if (strb.ersWr)  mem[scanIdx] <= 8'hFF;
  end

  assign statusByte = {(strb.ersMode ? 1'b0 : !tgtData[7]), togBit, 6'b000000};
  assign dataOe     = rdNow;
  assign dataOut    = rdNow ? (strb.busy ? statusByte : mem[rdIdx]) : 8'h00;

  logic unusedBits;
  assign unusedBits = ^{addr[ADDR_W-SEC_W-1:OFF_W], tgtAddr[ADDR_W-SEC_W-1:OFF_W]};

endmodule

// File: rtl/nfc_control.sv
module nfc_control
  import nfc_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int SECTOR_CNT   = 4,
  parameter int WIN_BYTES    = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int SEL_WINDOW   = 6,
  localparam int SEC_W = $clog2(SECTOR_CNT),
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int IDX_W = SEC_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lowVcc,
  input  logic                  wrEnd,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [7:0]            wrData,
  input  logic [SECTOR_CNT-1:0] protMask,
  output nfcStrb_t              strb,
  output logic [IDX_W-1:0]      scanIdx
);

  localparam int MEM_N = SECTOR_CNT * WIN_BYTES;
  localparam int MAX_A = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int MAX_C = (MAX_A > SEL_WINDOW) ? MAX_A : SEL_WINDOW;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SEL_LAST   = CNT_W'(SEL_WINDOW - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(MEM_N - 1);

  nfcState_t state, stNx, resumeSt;
  logic                  susp;
  logic [CNT_W-1:0]      cnt, pcnt;
  logic [SECTOR_CNT-1:0] selMask;
  logic                  cmd, unl1, unl2, suspReq, running;
  logic [SEC_W-1:0]      wrSec, scanSec;
  nfcState_t             baseSt;

  assign cmd     = wrEnd && !lowVcc;
  assign unl1    = cmd && (wrAddr[10:0] == 11'h555) && (wrData == 8'hAA);
  assign unl2    = cmd && (wrAddr[10:0] == 11'h2AA) && (wrData == 8'h55);
  assign suspReq = cmd && (wrData == 8'hB0);
  assign wrSec   = wrAddr[ADDR_W-1 -: SEC_W];
  assign scanSec = scanIdx[IDX_W-1 -: SEC_W];
  assign running = (state == S_EPRE) || (state == S_ETIME) || (state == S_EERS);
  assign baseSt  = susp ? S_SUSP : S_READ;

  // next state and strobes
  always_comb begin
    stNx         = state;
    strb         = '0;
    strb.ersMode = running || (state == S_ESEL);
    strb.busy    = strb.ersMode || (state == S_PRUN);
    case (state)
      S_READ, S_SUSP: begin
        if (cmd) begin
          if (unl1) stNx = S_UNL1;
          else if (state == S_SUSP && wrData == 8'h30) stNx = resumeSt;
          else stNx = baseSt;
        end
      end
      S_UNL1: if (cmd) stNx = unl2 ? S_UNL2 : baseSt;
      S_UNL2: begin
        if (cmd) begin
          if (wrData == 8'hA0) stNx = S_PWAIT;
          else if (wrData == 8'h80 && !susp) stNx = S_EUNL3;
          else stNx = baseSt;
        end
      end
      S_PWAIT: begin
        if (cmd) begin
          if (!protMask[wrSec] && !(susp && selMask[wrSec])) begin
            stNx          = S_PRUN;
            strb.tgtLatch = 1'b1;
          end else begin
            stNx = baseSt;
          end
        end
      end
      S_PRUN: begin
        if (pcnt == PROG_LAST) begin
          strb.progWr = 1'b1;
          stNx        = baseSt;
        end
      end
      S_EUNL3: if (cmd) stNx = unl1 ? S_EUNL4 : S_READ;
      S_EUNL4: if (cmd) stNx = unl2 ? S_EUNL5 : S_READ;
      S_EUNL5: if (cmd) stNx = (wrData == 8'h30) ? S_ESEL : S_READ;
      S_ESEL: begin
        if (cmd) stNx = (wrData == 8'h30) ? S_ESEL : S_READ;
        else if (cnt == SEL_LAST) stNx = (selMask != '0) ? S_EPRE : S_READ;
      end
      S_EPRE: begin
        if (suspReq) stNx = S_SUSP;
        else begin
          strb.preWr = selMask[scanSec];
          if (scanIdx == IDX_LAST) stNx = S_ETIME;
        end
      end
      S_ETIME: begin
        if (suspReq) stNx = S_SUSP;
        else if (cnt == ERASE_LAST) stNx = S_EERS;
      end
      S_EERS: begin
        if (suspReq) stNx = S_SUSP;
        else begin
          strb.ersWr = selMask[scanSec];
          if (scanIdx == IDX_LAST) stNx = S_READ;
        end
      end
      default: stNx = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_READ;
      resumeSt <= S_EPRE;
      susp     <= 1'b0;
      cnt      <= '0;
      pcnt     <= '0;
      scanIdx  <= '0;
      selMask  <= '0;
    end else begin
      state <= stNx;
      pcnt  <= (state == S_PRUN) ? pcnt + 1'b1 : '0;
      if (state == S_READ) selMask <= '0;
      // sector selection window
      if (cmd && wrData == 8'h30 && (state == S_EUNL5 || state == S_ESEL)) begin
        cnt <= '0;
        if (!protMask[wrSec]) selMask[wrSec] <= 1'b1;
      end else if (state == S_ESEL) begin
        cnt <= cnt + 1'b1;
      end
      if (state == S_ESEL && stNx == S_EPRE) begin
        cnt     <= '0;
        scanIdx <= '0;
      end
      // erase phases and suspension
      if (running && stNx == S_SUSP) begin
        susp     <= 1'b1;
        resumeSt <= state;
      end else begin
        if (state == S_EPRE || state == S_EERS) scanIdx <= scanIdx + 1'b1;
        if (state == S_EPRE && stNx == S_ETIME) begin
          scanIdx <= '0;
          cnt     <= '0;
        end
        if (state == S_ETIME) cnt <= cnt + 1'b1;
        if (state == S_ETIME && stNx == S_EERS) scanIdx <= '0;
      end
      if (state == S_SUSP && stNx == resumeSt) susp <= 1'b0;
    end
  end

  logic unusedBits;
  assign unusedBits = ^wrAddr[ADDR_W-SEC_W-1:11];

endmodule

// File: rtl/nor_flash_ctl.sv
module nor_flash_ctl
  import nfc_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int SECTOR_CNT   = 4,
  parameter int WIN_BYTES    = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int SEL_WINDOW   = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            dataIn,
  output logic [7:0]            dataOut,
  output logic                  dataOe,
  input  logic                  lowVcc,
  input  logic [SECTOR_CNT-1:0] protMask
);

  localparam int IDX_W = $clog2(SECTOR_CNT) + $clog2(WIN_BYTES);

  nfcStrb_t          strb;
  logic [IDX_W-1:0]  scanIdx;
  logic              wrEnd;
  logic [ADDR_W-1:0] wrAddr, tgtAddr;
  logic [7:0]        wrData;

  nfc_datapath #(
    .ADDR_W(ADDR_W), .SECTOR_CNT(SECTOR_CNT), .WIN_BYTES(WIN_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .strb(strb), .scanIdx(scanIdx),
    .wrEnd(wrEnd), .wrAddr(wrAddr), .wrData(wrData), .tgtAddr(tgtAddr),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  nfc_control #(
    .ADDR_W(ADDR_W), .SECTOR_CNT(SECTOR_CNT), .WIN_BYTES(WIN_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .SEL_WINDOW(SEL_WINDOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lowVcc(lowVcc), .wrEnd(wrEnd),
    .wrAddr(wrAddr), .wrData(wrData), .protMask(protMask),
    .strb(strb), .scanIdx(scanIdx)
  );

endmodule

// File: rtl/nor_flash_ctl_chk.sv
module nor_flash_ctl_chk
  import nfc_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SECTOR_CNT = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  lowVcc,
  input logic                  wrEnd,
  input nfcStrb_t              strb,
  input logic                  dataOe,
  input logic [7:0]            dataOut,
  input logic [SECTOR_CNT-1:0] protMask,
  input logic [ADDR_W-1:0]     tgtAddr
);

  localparam int SEC_W = $clog2(SECTOR_CNT);

  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == 8'h00);

  a_r3_status_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && strb.busy) |-> dataOut[5:0] == 6'h00);

  a_r3_toggle_steady_in_read: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && strb.busy && $past(dataOe) && $past(strb.busy)) |-> $stable(dataOut[6]));

  a_r9_lowvcc_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnd && lowVcc) |-> !strb.tgtLatch);

  a_r6_protected_no_prog: assert property (@(posedge clk) disable iff (!rstN)
    strb.progWr |-> !protMask[tgtAddr[ADDR_W-1 -: SEC_W]]);

  a_r4_single_array_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.progWr, strb.preWr, strb.ersWr}));

endmodule

bind nor_flash_ctl nor_flash_ctl_chk #(
  .ADDR_W(ADDR_W), .SECTOR_CNT(SECTOR_CNT)
) u_chk (
  .clk(clk), .rstN(rstN), .lowVcc(lowVcc), .wrEnd(wrEnd), .strb(strb),
  .dataOe(dataOe), .dataOut(dataOut), .protMask(protMask), .tgtAddr(tgtAddr)
);

// File: tb/nor_flash_ctl_tb.sv
module nor_flash_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] PROT = 4'b1000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rstN = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lowVcc = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] refMem [64];

  nor_flash_ctl #(
    .ADDR_W(18), .SECTOR_CNT(4), .WIN_BYTES(16),
    .PROG_CYCLES(8), .ERASE_CYCLES(40), .SEL_WINDOW(6)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .lowVcc(lowVcc), .protMask(PROT)
  );

  // {address, data} programmed in order
  localparam logic [25:0] VEC [6] = '{
    {18'h00003, 8'h5A}, {18'h10007, 8'hC3}, {18'h2000F, 8'h81},
    {18'h30002, 8'h00}, {18'h00003, 8'hF0}, {18'h1FFF7, 8'h3C}
  };

  function automatic int idxOf(input logic [17:0] a);
    return int'({a[17:16], a[3:0]});
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic busRead(input logic [17:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    #1 d = dataOut;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic unlock();
    busWrite(18'h00555, 8'hAA);
    busWrite(18'h002AA, 8'h55);
  endtask

  task automatic progSeq(input logic [17:0] a, input logic [7:0] d);
    unlock();
    busWrite(18'h00555, 8'hA0);
    busWrite(a, d);
  endtask

  task automatic eraseUnlock();
    unlock();
    busWrite(18'h00555, 8'h80);
    unlock();
  endtask

  task automatic waitReady(input logic [17:0] a, input string tag);
    logic [7:0] r1, r2;
    bit ok = 0;
    for (int n = 0; n < 1000 && !ok; n++) begin
      busRead(a, r1);
      busRead(a, r2);
      if (r1 == r2) ok = 1;
    end
    check(ok, tag, 32'(ok), 32'd1);
  endtask

  task automatic readCheck(input logic [17:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    busRead(a, r);
    check(r == exp, tag, 32'(r), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual cycles 100000 expected completion earlier");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r1, r2;
    logic [17:0] a;
    logic [7:0]  d;
    for (int i = 0; i < 64; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state: erased array, quiet bus (R1, R10)
    readCheck(18'h00000, 8'hFF, "R1 erased after reset");
    @(negedge clk);
    ceN = 1'b0;
    #1 check(dataOe == 1'b0 && dataOut == 8'h00, "R10 quiet with oeN high", 32'({dataOe, dataOut}), 32'h0);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b0;
    #1 check(dataOe == 1'b0 && dataOut == 8'h00, "R10 quiet with ceN high", 32'({dataOe, dataOut}), 32'h0);
    @(negedge clk);
    oeN = 1'b1;

    // vector table: AND programming, protection, aliasing (R4, R6, R1)
    for (int i = 0; i < 6; i++) begin
      a = VEC[i][25:8];
      d = VEC[i][7:0];
      progSeq(a, d);
      waitReady(a, "R4 program completes");
      if (!PROT[a[17:16]]) refMem[idxOf(a)] = refMem[idxOf(a)] & d;
      readCheck(a, refMem[idxOf(a)], "R4 R6 R1 table readback");
    end

    // status polling and writes ignored while busy (R3, R4)
    progSeq(18'h20001, 8'h7E);
    busRead(18'h20001, r1);
    busRead(18'h20001, r2);
    busWrite(18'h20001, 8'h00);
    check(r1[7] == 1'b1, "R3 DQ7 inverted", 32'(r1[7]), 32'd1);
    check(r1[6] != r2[6], "R3 DQ6 toggles", 32'(r2[6]), 32'(!r1[6]));
    check(r1[5:0] == 6'h00, "R3 low status bits", 32'(r1[5:0]), 32'h0);
    waitReady(18'h20001, "R3 status ends");
    refMem[idxOf(18'h20001)] = 8'h7E;
    readCheck(18'h20001, 8'h7E, "R4 busy write ignored");

    // broken sequence returns to read mode (R2)
    busWrite(18'h00555, 8'hAA);
    busWrite(18'h002AA, 8'h12);
    busWrite(18'h00555, 8'hA0);
    busWrite(18'h00005, 8'h00);
    readCheck(18'h00005, 8'hFF, "R2 broken sequence");
    unlock();
    busWrite(18'h00555, 8'hF0);
    busWrite(18'h00008, 8'h00);
    readCheck(18'h00008, 8'hFF, "R2 F0 aborts");

    // low supply inhibits writes (R9)
    lowVcc = 1'b1;
    progSeq(18'h00006, 8'h11);
    lowVcc = 1'b0;
    busRead(18'h00006, r1);
    busRead(18'h00006, r2);
    check(r1 == 8'hFF && r2 == 8'hFF, "R9 lowVcc inhibit", 32'({r1, r2}), 32'hFFFF);

    // erase of two sectors, others untouched (R5)
    eraseUnlock();
    busWrite(18'h10000, 8'h30);
    busWrite(18'h20000, 8'h30);
    busRead(18'h00003, r1);
    check(r1[7] == 1'b0, "R5 erase status DQ7", 32'(r1[7]), 32'd0);
    waitReady(18'h10000, "R5 erase completes");
    for (int j = 16; j < 48; j++) refMem[j] = 8'hFF;
    readCheck(18'h10007, 8'hFF, "R5 sector one erased");
    readCheck(18'h20001, 8'hFF, "R5 sector two erased");
    readCheck(18'h00003, refMem[idxOf(18'h00003)], "R5 sector zero kept");

    // erase window cancelled by other write (R5)
    progSeq(18'h10002, 8'h44);
    waitReady(18'h10002, "R5 setup program");
    refMem[idxOf(18'h10002)] = 8'h44;
    eraseUnlock();
    busWrite(18'h10000, 8'h30);
    busWrite(18'h10000, 8'hF0);
    repeat (20) @(negedge clk);
    readCheck(18'h10002, 8'h44, "R5 window cancel");

    // erase of protected sector never runs (R6)
    eraseUnlock();
    busWrite(18'h30000, 8'h30);
    repeat (12) @(negedge clk);
    busRead(18'h30002, r1);
    busRead(18'h30002, r2);
    check(r1 == 8'hFF && r2 == 8'hFF, "R6 protected erase idle", 32'({r1, r2}), 32'hFFFF);

    // suspend and resume (R7)
    progSeq(18'h00009, 8'h3F);
    waitReady(18'h00009, "R7 setup program");
    eraseUnlock();
    busWrite(18'h00000, 8'h30);
    repeat (80) @(negedge clk);
    busWrite(18'h00000, 8'hB0);
    readCheck(18'h00009, 8'h00, "R7 R5 preprogram seen in suspend");
    readCheck(18'h10002, 8'h44, "R7 other sector readable");
    progSeq(18'h10005, 8'h66);
    waitReady(18'h10005, "R7 suspend program");
    refMem[idxOf(18'h10005)] = 8'h66;
    readCheck(18'h10005, 8'h66, "R7 suspend program data");
    progSeq(18'h00001, 8'h12);
    readCheck(18'h00001, 8'h00, "R7 erasing sector not programmed");
    busWrite(18'h00000, 8'h30);
    waitReady(18'h00000, "R7 resume completes");
    for (int j = 0; j < 16; j++) refMem[j] = 8'hFF;
    readCheck(18'h00009, 8'hFF, "R7 resumed erase");

    // reset aborts a program (R8)
    progSeq(18'h20003, 8'h0F);
    busRead(18'h20003, r1);
    check(r1[7] == 1'b1 && r1[5:0] == 6'h00, "R8 busy before reset", 32'(r1), 32'h80);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    busRead(18'h20003, r1);
    busRead(18'h20003, r2);
    check(r1 == 8'hFF && r2 == 8'hFF, "R8 reset aborts", 32'({r1, r2}), 32'hFFFF);
    readCheck(18'h10005, 8'h66, "R8 array kept");

    // full array against model (R1)
    for (int j = 0; j < 64; j++) begin
      a = {j[5:4], 12'h000, j[3:0]};
      readCheck(a, refMem[j], "R1 final array");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule